// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores the architectural state of a floating-point coprocessor: eight result registers, a status word and a repeat-loop register. Two pipeline write ports and two combinational read ports serve the execution stages. A separate flag port updates chosen status bits without using a result-register write port. When the core takes a high-priority interrupt, it pulses `ctx_save`. In that single clock, every banked register is copied into a one-deep shadow bank. On return from the interrupt, `ctx_restore` copies the shadow bank back, also in a single clock. The repeat-loop register is not banked and keeps its live value through both operations.

When `EXT_EN` is set, each result register gets a paired upper-half register. This lets the register hold a 64-bit double-precision value. The upper half is banked together with the lower half.

The ports carry register traffic, not a data stream, so there is no valid/ready handshake. Every write that is presented is accepted in that cycle, and the file never applies back-pressure. Read data is combinational from the live registers. A write becomes visible on the read ports from the next cycle on.

Top module: `fprf_top`

## Requirements
- R1: After reset, all result registers, their upper halves, the status word, the repeat-loop register, the shadow bank and `shd_ovf` are zero.
- R2: A write on port A or port B updates the addressed register at the clock edge. The new value appears on both read ports from the next cycle. The read ports show the addressed live register combinationally.
- R3: When both write ports address the same register in one cycle, port B's data is stored.
- R4: The upper half of a register is written only when its port's write enable and its `*_hi_en` bit are both 1. Otherwise the upper half keeps its value. The upper half is read on `ra_hi`/`rb_hi`.
- R5: A flag write replaces exactly those status bits whose `flg_mask` bit is 1 with the matching `flg_val` bits. All other status bits are kept. This is independent of any result-register write in the same cycle.
- R6: `ctx_save` copies all result registers, their upper halves and the status word into the shadow bank at one edge. The copy holds the values that were live before that edge.
- R7: `ctx_restore` returns the shadow bank to the live registers at one edge. The restored values are readable in the next cycle.
- R8: In a cycle with `ctx_restore`, the restored value wins over a pipeline write or a flag write to the same register.
- R9: The repeat-loop register is unchanged by save and restore. It is changed only by `rpt_wr_en`.
- R10: A save issued while the shadow bank already holds an unrestored copy overwrites that copy and sets `shd_ovf`. `shd_ovf` stays 1 until reset.
- R11: Save and restore in the same cycle swap the live and shadow banks. This does not set `shd_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wa_en | input | 1 | Write port A enable |
| wa_idx | input | 3 | Write port A register index |
| wa_data | input | 32 | Write port A lower half |
| wa_hi_en | input | 1 | Write port A upper-half enable |
| wa_hi | input | 32 | Write port A upper half |
| wb_en | input | 1 | Write port B enable |
| wb_idx | input | 3 | Write port B register index |
| wb_data | input | 32 | Write port B lower half |
| wb_hi_en | input | 1 | Write port B upper-half enable |
| wb_hi | input | 32 | Write port B upper half |
| ra_idx | input | 3 | Read port A index |
| ra_data | output | 32 | Read port A lower half |
| ra_hi | output | 32 | Read port A upper half |
| rb_idx | input | 3 | Read port B index |
| rb_data | output | 32 | Read port B lower half |
| rb_hi | output | 32 | Read port B upper half |
| flg_en | input | 1 | Status flag write enable |
| flg_mask | input | 32 | Status bits to replace |
| flg_val | input | 32 | New status bit values |
| st_q | output | 32 | Live status word |
| rpt_wr_en | input | 1 | Repeat-loop register write enable |
| rpt_wr_data | input | 32 | Repeat-loop register write data |
| rpt_q | output | 32 | Repeat-loop register value |
| ctx_save | input | 1 | Copy live bank into shadow |
| ctx_restore | input | 1 | Copy shadow bank into live |
| shd_ovf | output | 1 | Sticky shadow overflow flag |

## Verification
On every cycle, the assertions check the following:
- A save leaves the shadow equal to the live values from one cycle earlier, and a restore leaves the live values equal to the previous shadow (R6, R7).
- A pipeline write without a restore lands in its register (R2).
- A flag write leaves the unmasked status bits untouched (R5).
- The repeat-loop register holds through save and restore (R9).
- The overflow flag is set by a second save and never drops (R10).

Only the bench scenarios can show the following:
- Port-B priority on a same-index write (R3).
- The value that comes out after a full interrupt sequence with writes between save and restore.
- The swap on a simultaneous save and restore (R11).
- That the restored values are the ones from the first or the second save.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef struct packed {
    logic save;
    logic restore;
  } shd_cmd_t;
endpackage

// File: rtl/fprf_cell.sv
module fprf_cell
  import fprf_pkg::*;
#(
  parameter int DW     = 32,
  parameter bit EXT_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shd_cmd_t      cmd,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_lo,
  input  logic          wr_hi_en,
  input  logic [DW-1:0] wr_hi,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q
);
  logic [DW-1:0] sh_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      sh_lo <= '0;
    end else begin
      if (cmd.restore)  lo_q <= sh_lo;
      else if (wr_en)   lo_q <= wr_lo;
      if (cmd.save)     sh_lo <= lo_q;
    end
  end

  generate
    if (EXT_EN) begin : g_ext
      logic [DW-1:0] hi_r, sh_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_r  <= '0;
          sh_hi <= '0;
        end else begin
          if (cmd.restore)              hi_r <= sh_hi;
          else if (wr_en && wr_hi_en)   hi_r <= wr_hi;
          if (cmd.save)                 sh_hi <= hi_r;
        end
      end
      assign hi_q = hi_r;
    end else begin : g_noext
      assign hi_q = '0;
    end
  endgenerate

  // R6
  save_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.save |=> sh_lo == $past(lo_q));
  // R7
  restore_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.restore |=> lo_q == $past(sh_lo));
  // R2
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cmd.restore) |=> lo_q == $past(wr_lo));
endmodule

// File: rtl/fprf_status.sv
module fprf_status
  import fprf_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shd_cmd_t      cmd,
  input  logic          flg_en,
  input  logic [SW-1:0] flg_mask,
  input  logic [SW-1:0] flg_val,
  output logic [SW-1:0] st_q
);
  logic [SW-1:0] sh_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      sh_st <= '0;
    end else begin
      if (cmd.restore)  st_q <= sh_st;
      else if (flg_en)  st_q <= (st_q & ~flg_mask) | (flg_val & flg_mask);
      if (cmd.save)     sh_st <= st_q;
    end
  end

  // R5
  flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_en && !cmd.restore) |=> ((st_q ^ $past(st_q)) & ~$past(flg_mask)) == '0);
  // R8
  flag_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.restore |=> st_q == $past(sh_st));
endmodule

// File: rtl/fprf_shadow_ctl.sv
module fprf_shadow_ctl
  import fprf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  shd_cmd_t cmd,
  output logic     ovf
);
  logic full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (cmd.save)         full <= 1'b1;
      else if (cmd.restore) full <= 1'b0;
      if (cmd.save && full && !cmd.restore) ovf <= 1'b1;
    end
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.save && full && !cmd.restore) |=> ovf);
endmodule

// File: rtl/fprf_top.sv
module fprf_top
  import fprf_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int SW     = 32,
  parameter bit EXT_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wa_en,
  input  logic [$clog2(NREG)-1:0] wa_idx,
  input  logic [DW-1:0]           wa_data,
  input  logic                    wa_hi_en,
  input  logic [DW-1:0]           wa_hi,
  input  logic                    wb_en,
  input  logic [$clog2(NREG)-1:0] wb_idx,
  input  logic [DW-1:0]           wb_data,
  input  logic                    wb_hi_en,
  input  logic [DW-1:0]           wb_hi,
  input  logic [$clog2(NREG)-1:0] ra_idx,
  output logic [DW-1:0]           ra_data,
  output logic [DW-1:0]           ra_hi,
  input  logic [$clog2(NREG)-1:0] rb_idx,
  output logic [DW-1:0]           rb_data,
  output logic [DW-1:0]           rb_hi,
  input  logic                    flg_en,
  input  logic [SW-1:0]           flg_mask,
  input  logic [SW-1:0]           flg_val,
  output logic [SW-1:0]           st_q,
  input  logic                    rpt_wr_en,
  input  logic [DW-1:0]           rpt_wr_data,
  output logic [DW-1:0]           rpt_q,
  input  logic                    ctx_save,
  input  logic                    ctx_restore,
  output logic                    shd_ovf
);
  localparam int IW = $clog2(NREG);

  shd_cmd_t      cmd;
  logic [DW-1:0] lo_arr [NREG];
  logic [DW-1:0] hi_arr [NREG];

  assign cmd.save    = ctx_save;
  assign cmd.restore = ctx_restore;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic sel_a, sel_b;
      assign sel_a = wa_en && (wa_idx == IW'(i));
      assign sel_b = wb_en && (wb_idx == IW'(i));
      fprf_cell #(.DW(DW), .EXT_EN(EXT_EN)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .wr_en    (sel_a || sel_b),
        .wr_lo    (sel_b ? wb_data  : wa_data),
        .wr_hi_en (sel_b ? wb_hi_en : wa_hi_en),
        .wr_hi    (sel_b ? wb_hi    : wa_hi),
        .lo_q     (lo_arr[i]),
        .hi_q     (hi_arr[i])
      );
    end
  endgenerate

  assign ra_data = lo_arr[ra_idx];
  assign ra_hi   = hi_arr[ra_idx];
  assign rb_data = lo_arr[rb_idx];
  assign rb_hi   = hi_arr[rb_idx];

  fprf_status #(.SW(SW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .flg_en   (flg_en),
    .flg_mask (flg_mask),
    .flg_val  (flg_val),
    .st_q     (st_q)
  );

  fprf_shadow_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .ovf   (shd_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rpt_q <= '0;
    else if (rpt_wr_en) rpt_q <= rpt_wr_data;
  end

  // R9
  rpt_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctx_save || ctx_restore) && !rpt_wr_en) |=> $stable(rpt_q));
endmodule

// File: tb/tb_fprf_top.sv
`timescale 1ns/1ps
module tb_fprf_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic wa_en = 0, wa_hi_en = 0, wb_en = 0, wb_hi_en = 0;
  logic [2:0] wa_idx = 0, wb_idx = 0, ra_idx = 0, rb_idx = 0;
  logic [31:0] wa_data = 0, wa_hi = 0, wb_data = 0, wb_hi = 0;
  logic [31:0] ra_data, ra_hi, rb_data, rb_hi, st_q, rpt_q;
  logic flg_en = 0, rpt_wr_en = 0, ctx_save = 0, ctx_restore = 0, shd_ovf;
  logic [31:0] flg_mask = 0, flg_val = 0, rpt_wr_data = 0;

  fprf_top dut (.*);

  typedef struct {
    int          kind;
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [31:0] m_lo [8], m_hi [8], s_lo [8], s_hi [8];
  logic [31:0] m_st = 0, s_st = 0, m_rpt = 0;
  logic m_full = 0, m_ovf = 0;

  task automatic tick();
    logic [31:0] n_lo [8], n_hi [8];
    for (int i = 0; i < 8; i++) begin
      n_lo[i] = m_lo[i]; n_hi[i] = m_hi[i];
      if (ctx_restore) begin n_lo[i] = s_lo[i]; n_hi[i] = s_hi[i]; end
      else if (wb_en && wb_idx == i) begin
        n_lo[i] = wb_data; if (wb_hi_en) n_hi[i] = wb_hi;
      end else if (wa_en && wa_idx == i) begin
        n_lo[i] = wa_data; if (wa_hi_en) n_hi[i] = wa_hi;
      end
      if (ctx_save) begin s_lo[i] = m_lo[i]; s_hi[i] = m_hi[i]; end
    end
    for (int i = 0; i < 8; i++) begin m_lo[i] = n_lo[i]; m_hi[i] = n_hi[i]; end
    if (ctx_restore) begin
      if (ctx_save) begin logic [31:0] t; t = m_st; m_st = s_st; s_st = t; end
      else m_st = s_st;
    end else begin
      if (ctx_save) s_st = m_st;
      if (flg_en) m_st = (m_st & ~flg_mask) | (flg_val & flg_mask);
    end
    if (rpt_wr_en) m_rpt = rpt_wr_data;
    if (ctx_save && m_full && !ctx_restore) m_ovf = 1;
    if (ctx_save) m_full = 1; else if (ctx_restore) m_full = 0;
    @(posedge clk);
    @(negedge clk);
    wa_en = 0; wb_en = 0; wa_hi_en = 0; wb_hi_en = 0; flg_en = 0;
    rpt_wr_en = 0; ctx_save = 0; ctx_restore = 0;
  endtask

  task automatic chk_reg(int port, int idx, string tag);
    item_t it;
    if (port == 0) ra_idx = 3'(idx); else rb_idx = 3'(idx);
    it.kind = port; it.lo = m_lo[idx]; it.hi = m_hi[idx]; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_misc(int kind, string tag);
    item_t it;
    it.kind = kind; it.hi = 0; it.tag = tag;
    it.lo = (kind == 2) ? m_st : (kind == 3) ? m_rpt : {31'b0, m_ovf};
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr_a(int idx, logic [31:0] lo, logic hen, logic [31:0] hi);
    wa_en = 1; wa_idx = 3'(idx); wa_data = lo; wa_hi_en = hen; wa_hi = hi;
  endtask
  task automatic wr_b(int idx, logic [31:0] lo, logic hen, logic [31:0] hi);
    wb_en = 1; wb_idx = 3'(idx); wb_data = lo; wb_hi_en = hen; wb_hi = hi;
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] alo, ahi;
        it = q.pop_front();
        case (it.kind)
          0: begin alo = ra_data; ahi = ra_hi; end
          1: begin alo = rb_data; ahi = rb_hi; end
          2: begin alo = st_q; ahi = 0; end
          3: begin alo = rpt_q; ahi = 0; end
          default: begin alo = {31'b0, shd_ovf}; ahi = 0; end
        endcase
        checks++;
        if (alo !== it.lo || ahi !== it.hi) begin
          fails++;
          $display("FAIL %s: actual lo=%h hi=%h expected lo=%h hi=%h",
                   it.tag, alo, ahi, it.lo, it.hi);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; s_lo[i] = 0; s_hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_reg(0, 0, "R1 reg0"); chk_reg(1, 7, "R1 reg7");
    chk_misc(2, "R1 status"); chk_misc(3, "R1 rpt"); chk_misc(4, "R1 ovf");
    // R2 / R4 two ports, distinct registers
    wr_a(1, 32'h3f80_0000, 1, 32'h0000_0011);
    wr_b(2, 32'h4000_0000, 1, 32'h0000_0022);
    tick();
    chk_reg(0, 1, "R2 port A write"); chk_reg(1, 2, "R2 port B write");
    chk_reg(1, 1, "R2 read port B sees A write");
    // R3 same index
    wr_a(5, 32'hAAAA_0000, 1, 32'h5A5A_5A5A);
    wr_b(5, 32'hBBBB_0000, 1, 32'hB5B5_B5B5);
    tick();
    chk_reg(0, 5, "R3 port B wins");
    // R4 lower half only
    wr_a(1, 32'h1234_5678, 0, 32'hDEAD_BEEF);
    tick();
    chk_reg(0, 1, "R4 upper half kept");
    // R5 flag writes, one alongside a result write
    flg_en = 1; flg_mask = 32'h0000_00F0; flg_val = 32'hFFFF_FFFF;
    tick();
    chk_misc(2, "R5 set masked bits");
    flg_en = 1; flg_mask = 32'h0000_0030; flg_val = 32'h0;
    wr_a(3, 32'h0303_0303, 1, 32'h3333_3333);
    tick();
    chk_misc(2, "R5 clear masked bits"); chk_reg(0, 3, "R5 independent write");
    rpt_wr_en = 1; rpt_wr_data = 32'h0000_ABCD;
    tick();
    chk_misc(3, "R9 rpt write");
    // R6 save, then modify everything
    ctx_save = 1;
    tick();
    wr_a(1, 32'hC0DE_0001, 1, 32'hC0DE_1001);
    wr_b(2, 32'hC0DE_0002, 1, 32'hC0DE_1002);
    flg_en = 1; flg_mask = 32'hFFFF_FFFF; flg_val = 32'h0000_0007;
    rpt_wr_en = 1; rpt_wr_data = 32'h0000_0099;
    tick();
    chk_reg(0, 1, "R6 live after save"); chk_misc(2, "R6 status live");
    // R7 / R8 restore beats pipeline and flag writes
    ctx_restore = 1;
    wr_a(1, 32'hFFFF_0000, 1, 32'hFFFF_1111);
    flg_en = 1; flg_mask = 32'hFFFF_FFFF; flg_val = 32'hFFFF_FFFF;
    tick();
    chk_reg(0, 1, "R8 restore beats write"); chk_reg(1, 2, "R7 reg2 restored");
    chk_reg(0, 5, "R7 reg5 restored");
    chk_misc(2, "R8 status restored"); chk_misc(3, "R9 rpt kept");
    chk_misc(4, "R10 no ovf yet");
    // R10 double save
    ctx_save = 1;
    tick();
    wr_a(4, 32'h4444_0004, 1, 32'h4444_1004);
    tick();
    ctx_save = 1;
    tick();
    chk_misc(4, "R10 ovf set");
    wr_a(4, 32'h0, 1, 32'h0);
    tick();
    ctx_restore = 1;
    tick();
    chk_reg(0, 4, "R10 second save restored");
    chk_misc(4, "R10 ovf sticky");
    // R11 swap
    ctx_save = 1;
    tick();
    wr_b(6, 32'h6666_0006, 1, 32'h6666_1006);
    tick();
    ctx_save = 1; ctx_restore = 1;
    tick();
    chk_reg(1, 6, "R11 swap live");
    ctx_restore = 1;
    tick();
    chk_reg(1, 6, "R11 swap shadow");
    chk_misc(3, "R9 rpt after swap");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule